// File: doc/BRIEF.md
# DMA Bus Request Arbiter

This block sits in front of a bus-mastering DMA engine and decides when the engine asks for the bus. It also decides which of its two channels gets serviced. The outbound (write) channel moves data from a local FIFO onto the bus. The inbound (read) channel moves data from the bus into a second FIFO. Each channel is qualified by:

- its enable bit,
- a non-zero transfer count,
- the state of its FIFO.

For the outbound FIFO, an optional four-word fill threshold holds back the request until a useful burst is available. The threshold is waived once the bus is granted or is already held for write work.

Two priority bits select the arbitration mode:

- fixed read-first,
- equal alternation between the channels,
- first-come order.

The fourth combination of the two bits is illegal. The block flags it and refuses to request the bus. The block also decodes eight status flags from the transfer counts and FIFO fill levels. It signals a suspended write when the write enable is cleared with work still outstanding.

The request and channel outputs are registered. A request starts in the clock after its channel qualifies. It is held until the channel is aborted or a burst completes. The bus protocol, the FIFOs and address generation sit outside this block.

Top module: `busreq_arbiter`

## Requirements
- R1: The status flags are combinational decodes of the inputs (FIFO depth 8):
  - `out_cnt_zero` is set when `out_count` is 0; `in_cnt_zero` is set when `in_count` is 0.
  - `out_empty` is set when `out_fill` is 0; `out_full` is set when `out_fill` is 8.
  - `out_four_plus` is set when `out_fill` is 4 or more.
  - `in_empty` is set when `in_fill` is 0; `in_full` is set when `in_fill` is 8.
  - `in_four_free` is set when `8 - in_fill` is 4 or more.
- R2: With `cfg_wr_gate4` = 0, the write channel qualifies when all three hold: `cfg_wr_en` = 1, `out_count` is non-zero and `out_fill` is at least 1. A qualifying write raises `bus_req` with `chan_sel` = 1 one clock later. A write is never started with the enable low or the count zero.
- R3: With `cfg_wr_gate4` = 1, the write channel additionally needs `out_fill` of 4 or more. The exception is when `bus_grant` is high, in which case the threshold is waived.
- R4: Once a write request is raised, a drop of `out_fill` below four does not withdraw it. This holds while waiting for the grant and while owning the bus.
- R5: The read channel qualifies when all three hold: `cfg_rd_en` = 1, `in_count` is non-zero and `in_fill` is below 8. A qualifying read raises `bus_req` with `chan_sel` = 0 one clock later.
- R6: With {`cfg_wr_first`,`cfg_rd_first`} = 01, a qualifying read always wins over a qualifying write.
- R7: With both priority bits set and both channels qualifying, service alternates read, write, read, and so on. The first pick after reset is read. The turn pointer moves only when a burst completes while the other channel qualifies.
- R8: With both priority bits clear, the channel that qualified first is served. When both qualify in the same clock, read is served.
- R9: With {`cfg_wr_first`,`cfg_rd_first`} = 10, `cfg_error` is 1. In that mode no request is raised, and an active request is dropped one clock later.
- R10: `wr_suspend` is 1 exactly when `cfg_wr_en` is 0 and `out_count` is non-zero. An active write request drops one clock after the enable is cleared.
- R11: After `bus_grant`, `bus_req` stays high until `burst_done` is seen, then it falls one clock later. Without `bus_grant`, the request and channel are held.
- R12: After reset, `bus_req` is 0 and `chan_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rd_first | input | 1 | Read-priority bit |
| cfg_wr_first | input | 1 | Write-priority bit |
| cfg_wr_en | input | 1 | Write channel enable |
| cfg_rd_en | input | 1 | Read channel enable |
| cfg_wr_gate4 | input | 1 | Four-word outbound threshold mode |
| out_count | input | CNT_W | Remaining outbound transfer count |
| in_count | input | CNT_W | Remaining inbound transfer count |
| out_fill | input | FILL_W | Valid words in outbound FIFO |
| in_fill | input | FILL_W | Valid words in inbound FIFO |
| bus_grant | input | 1 | Bus granted to this master |
| burst_done | input | 1 | Current burst has completed |
| bus_req | output | 1 | Bus request |
| chan_sel | output | 1 | Serviced channel, 1 write, 0 read |
| cfg_error | output | 1 | Illegal priority combination |
| wr_suspend | output | 1 | Write suspended with work pending |
| out_cnt_zero | output | 1 | Outbound count is zero |
| in_cnt_zero | output | 1 | Inbound count is zero |
| out_empty | output | 1 | Outbound FIFO empty |
| out_four_plus | output | 1 | Outbound FIFO holds four or more words |
| out_full | output | 1 | Outbound FIFO full |
| in_empty | output | 1 | Inbound FIFO empty |
| in_four_free | output | 1 | Inbound FIFO has four or more free words |
| in_full | output | 1 | Inbound FIFO full |

## Verification
The write qualification is swept over every fill level from empty to full, and over both threshold modes, grant levels, enable values and zero or non-zero counts. This separates the one-word rule from the four-word rule and shows where the grant waives the threshold. The read qualification and the status decode are swept across all fill levels and count cases, which pins the full and four-free boundaries. Arbitration is tried with both channels becoming ready together and with one ready before the other. This is repeated in each priority mode over several successive bursts, which tells fixed priority, alternation, first-come order and the tie rule apart. Dropping the fill under an active request and clearing the enable mid-transfer separate the threshold waiver from the suspend path.

// File: rtl/busreq_pkg.sv
package busreq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_OWN  = 2'd2
  } arb_state_e;

  typedef enum logic {
    CH_RD = 1'b0,
    CH_WR = 1'b1
  } chan_e;

  // encoded as {write-priority bit, read-priority bit}
  typedef enum logic [1:0] {
    PM_FIRST = 2'b00,
    PM_RDFIX = 2'b01,
    PM_BAD   = 2'b10,
    PM_ALT   = 2'b11
  } prio_mode_e;

endpackage

// File: rtl/busreq_rstsync.sv
module busreq_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/busreq_status.sv
module busreq_status #(
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 8,
  parameter int THRESH = 4,
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0]  out_count,
  input  logic [CNT_W-1:0]  in_count,
  input  logic [FILL_W-1:0] out_fill,
  input  logic [FILL_W-1:0] in_fill,
  output logic              out_cnt_zero,
  output logic              in_cnt_zero,
  output logic              out_empty,
  output logic              out_four_plus,
  output logic              out_full,
  output logic              in_empty,
  output logic              in_four_free,
  output logic              in_full
);
  localparam logic [FILL_W-1:0] DEPTH_V = FILL_W'(DEPTH);
  localparam logic [FILL_W-1:0] THR_V   = FILL_W'(THRESH);

  logic [FILL_W-1:0] in_space;

  always_comb begin
    in_space      = DEPTH_V - in_fill;
    out_cnt_zero  = (out_count == '0);
    in_cnt_zero   = (in_count == '0);
    out_empty     = (out_fill == '0);
    out_four_plus = (out_fill >= THR_V);
    out_full      = (out_fill == DEPTH_V);
    in_empty      = (in_fill == '0);
    in_four_free  = (in_space >= THR_V);
    in_full       = (in_fill == DEPTH_V);
  end
endmodule

// File: rtl/busreq_qualify.sv
module busreq_qualify #(
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 8,
  parameter int THRESH = 4,
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              wr_gate4,
  input  logic [CNT_W-1:0]  out_count,
  input  logic [CNT_W-1:0]  in_count,
  input  logic [FILL_W-1:0] out_fill,
  input  logic [FILL_W-1:0] in_fill,
  input  logic              bus_grant,
  input  logic              hold_wr,
  output logic              wr_pend,
  output logic              rd_pend
);
  localparam logic [FILL_W-1:0] DEPTH_V = FILL_W'(DEPTH);
  localparam logic [FILL_W-1:0] THR_V   = FILL_W'(THRESH);

  logic wr_base;
  logic wr_fill_ok;
  logic gate_waived;

  always_comb begin
    wr_base     = wr_en && (out_count != '0) && (out_fill != '0);
    gate_waived = bus_grant || hold_wr;
    wr_fill_ok  = !wr_gate4 || gate_waived || (out_fill >= THR_V);
    wr_pend     = wr_base && wr_fill_ok;
    rd_pend     = rd_en && (in_count != '0) && (in_fill < DEPTH_V);
  end
endmodule

// File: rtl/busreq_select.sv
module busreq_select
  import busreq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  prio_mode_e mode,
  input  logic       rd_pend,
  input  logic       wr_pend,
  input  logic       adv,
  input  chan_e      cur_ch,
  output logic       pick_valid,
  output chan_e      pick_ch,
  output logic       bad_cfg
);
  logic  alt_q, alt_d, alt_en;
  logic  older_wr_q, older_wr_d;
  logic  both;
  chan_e single_ch;

  always_comb begin
    both      = rd_pend && wr_pend;
    single_ch = wr_pend ? CH_WR : CH_RD;
    bad_cfg   = (mode == PM_BAD);
    unique case (mode)
      PM_RDFIX: pick_ch = rd_pend ? CH_RD : CH_WR;
      PM_ALT:   pick_ch = both ? chan_e'(alt_q) : single_ch;
      default:  pick_ch = both ? (older_wr_q ? CH_WR : CH_RD) : single_ch;
    endcase
    pick_valid = (rd_pend || wr_pend) && !bad_cfg;
  end

  always_comb begin
    alt_en     = adv;
    alt_d      = (cur_ch == CH_RD);
    older_wr_d = both ? older_wr_q : wr_pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alt_q      <= 1'b0;
      older_wr_q <= 1'b0;
    end else begin
      if (alt_en) alt_q <= alt_d;
      older_wr_q <= older_wr_d;
    end
  end

  // R7
  alt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(alt_q));

endmodule

// File: rtl/busreq_arbiter.sv
module busreq_arbiter
  import busreq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 8,
  parameter int THRESH = 4,
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_rd_first,
  input  logic              cfg_wr_first,
  input  logic              cfg_wr_en,
  input  logic              cfg_rd_en,
  input  logic              cfg_wr_gate4,
  input  logic [CNT_W-1:0]  out_count,
  input  logic [CNT_W-1:0]  in_count,
  input  logic [FILL_W-1:0] out_fill,
  input  logic [FILL_W-1:0] in_fill,
  input  logic              bus_grant,
  input  logic              burst_done,
  output logic              bus_req,
  output logic              chan_sel,
  output logic              cfg_error,
  output logic              wr_suspend,
  output logic              out_cnt_zero,
  output logic              in_cnt_zero,
  output logic              out_empty,
  output logic              out_four_plus,
  output logic              out_full,
  output logic              in_empty,
  output logic              in_four_free,
  output logic              in_full
);
  logic       rst_ns;
  arb_state_e state_q, state_d;
  chan_e      chan_q, chan_d;
  logic       chan_en;
  prio_mode_e mode;
  logic       wr_pend, rd_pend;
  logic       hold_wr;
  logic       pick_valid;
  chan_e      pick_ch;
  logic       bad_cfg;
  logic       abort;
  logic       other_pend;
  logic       adv;

  busreq_rstsync #(.STAGES(2)) i_rstsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ns)
  );

  busreq_status #(.DEPTH(DEPTH), .CNT_W(CNT_W), .THRESH(THRESH)) i_status (
    .out_count     (out_count),
    .in_count      (in_count),
    .out_fill      (out_fill),
    .in_fill       (in_fill),
    .out_cnt_zero  (out_cnt_zero),
    .in_cnt_zero   (in_cnt_zero),
    .out_empty     (out_empty),
    .out_four_plus (out_four_plus),
    .out_full      (out_full),
    .in_empty      (in_empty),
    .in_four_free  (in_four_free),
    .in_full       (in_full)
  );

  assign hold_wr = (state_q != ST_IDLE) && (chan_q == CH_WR);

  busreq_qualify #(.DEPTH(DEPTH), .CNT_W(CNT_W), .THRESH(THRESH)) i_qualify (
    .wr_en     (cfg_wr_en),
    .rd_en     (cfg_rd_en),
    .wr_gate4  (cfg_wr_gate4),
    .out_count (out_count),
    .in_count  (in_count),
    .out_fill  (out_fill),
    .in_fill   (in_fill),
    .bus_grant (bus_grant),
    .hold_wr   (hold_wr),
    .wr_pend   (wr_pend),
    .rd_pend   (rd_pend)
  );

  assign mode = prio_mode_e'({cfg_wr_first, cfg_rd_first});

  busreq_select i_select (
    .clk        (clk),
    .rst_n      (rst_ns),
    .mode       (mode),
    .rd_pend    (rd_pend),
    .wr_pend    (wr_pend),
    .adv        (adv),
    .cur_ch     (chan_q),
    .pick_valid (pick_valid),
    .pick_ch    (pick_ch),
    .bad_cfg    (bad_cfg)
  );

  always_comb begin
    if (chan_q == CH_WR) begin
      abort      = bad_cfg || !cfg_wr_en || (out_count == '0);
      other_pend = rd_pend;
    end else begin
      abort      = bad_cfg || !cfg_rd_en || (in_count == '0);
      other_pend = wr_pend;
    end
    adv = (state_q == ST_OWN) && burst_done && !abort && other_pend;
  end

  always_comb begin
    state_d = state_q;
    chan_d  = pick_ch;
    chan_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (pick_valid) begin
          state_d = ST_REQ;
          chan_en = 1'b1;
        end
      end
      ST_REQ: begin
        if (abort)          state_d = ST_IDLE;
        else if (bus_grant) state_d = ST_OWN;
      end
      ST_OWN: begin
        if (abort || burst_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= ST_IDLE;
      chan_q  <= CH_RD;
    end else begin
      state_q <= state_d;
      if (chan_en) chan_q <= chan_d;
    end
  end

  assign bus_req    = (state_q != ST_IDLE);
  assign chan_sel   = chan_q;
  assign cfg_error  = bad_cfg;
  assign wr_suspend = !cfg_wr_en && (out_count != '0);

  // R9
  bad_cfg_drop_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    cfg_error |=> !bus_req);

  // R10
  wr_suspend_drop_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (bus_req && chan_sel && !cfg_wr_en) |=> !bus_req);

  // R2
  wr_start_qual_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    ($rose(bus_req) && chan_sel) |-> ($past(cfg_wr_en) && $past(out_count != '0)));

  // R6
  rd_first_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (state_q == ST_IDLE && rd_pend && mode == PM_RDFIX) |=> (bus_req && !chan_sel));

  // R11
  own_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (state_q == ST_OWN && !burst_done && !abort) |=> bus_req);

endmodule

// File: tb/test_busreq_arbiter.sv
module test_busreq_arbiter;
  localparam int DEPTH  = 8;
  localparam int CNT_W  = 8;
  localparam int FILL_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_rd_first, cfg_wr_first, cfg_wr_en, cfg_rd_en, cfg_wr_gate4;
  logic [CNT_W-1:0]  out_count, in_count;
  logic [FILL_W-1:0] out_fill, in_fill;
  logic bus_grant, burst_done;
  logic bus_req, chan_sel, cfg_error, wr_suspend;
  logic out_cnt_zero, in_cnt_zero, out_empty, out_four_plus, out_full;
  logic in_empty, in_four_free, in_full;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  busreq_arbiter #(.DEPTH(DEPTH), .CNT_W(CNT_W), .THRESH(4)) i_busreq_arbiter (
    .clk(clk), .rst_n(rst_n),
    .cfg_rd_first(cfg_rd_first), .cfg_wr_first(cfg_wr_first),
    .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en), .cfg_wr_gate4(cfg_wr_gate4),
    .out_count(out_count), .in_count(in_count),
    .out_fill(out_fill), .in_fill(in_fill),
    .bus_grant(bus_grant), .burst_done(burst_done),
    .bus_req(bus_req), .chan_sel(chan_sel), .cfg_error(cfg_error),
    .wr_suspend(wr_suspend),
    .out_cnt_zero(out_cnt_zero), .in_cnt_zero(in_cnt_zero),
    .out_empty(out_empty), .out_four_plus(out_four_plus), .out_full(out_full),
    .in_empty(in_empty), .in_four_free(in_four_free), .in_full(in_full)
  );

  task automatic cyc;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic quiet;
    cfg_wr_en = 0; cfg_rd_en = 0; bus_grant = 0; burst_done = 0;
    cyc; cyc;
  endtask

  task automatic do_reset;
    cfg_rd_first = 0; cfg_wr_first = 0; cfg_wr_en = 0; cfg_rd_en = 0;
    cfg_wr_gate4 = 0; out_count = 0; in_count = 0; out_fill = 0; in_fill = 0;
    bus_grant = 0; burst_done = 0;
    rst_n = 0;
    cyc; cyc;
    rst_n = 1;
    cyc; cyc; cyc;
  endtask

  // one burst: own the bus, complete it, then the next request appears
  task automatic next_burst;
    cyc;
    burst_done = 1;
    cyc;
    burst_done = 0;
    cyc;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset;
    // R12 reset state
    check("R12 bus_req", int'(bus_req), 0);
    check("R12 chan_sel", int'(chan_sel), 0);

    // R1 status decode sweep
    for (int f = 0; f <= DEPTH; f++) begin
      for (int c = 0; c < 3; c++) begin
        out_fill = FILL_W'(f); in_fill = FILL_W'(DEPTH - f);
        out_count = CNT_W'(c * 7); in_count = CNT_W'((2 - c) * 5);
        #1;
        check("R1 out_cnt_zero", int'(out_cnt_zero), int'(c == 0));
        check("R1 in_cnt_zero", int'(in_cnt_zero), int'(c == 2));
        check("R1 out_empty", int'(out_empty), int'(f == 0));
        check("R1 out_four_plus", int'(out_four_plus), int'(f >= 4));
        check("R1 out_full", int'(out_full), int'(f == DEPTH));
        check("R1 in_empty", int'(in_empty), int'(DEPTH - f == 0));
        check("R1 in_four_free", int'(in_four_free), int'(f >= 4));
        check("R1 in_full", int'(in_full), int'(f == 0));
        check("R10 wr_suspend", int'(wr_suspend), int'(c != 0));
      end
    end
    @(negedge clk);

    // R2 R3 write qualification sweep (read channel disabled)
    cfg_rd_first = 1; cfg_wr_first = 0;
    for (int g4 = 0; g4 < 2; g4++)
      for (int f = 0; f <= DEPTH; f++)
        for (int gr = 0; gr < 2; gr++)
          for (int en = 0; en < 2; en++)
            for (int cz = 0; cz < 2; cz++) begin
              cfg_wr_gate4 = g4[0]; out_fill = FILL_W'(f); bus_grant = gr[0];
              cfg_wr_en = en[0]; out_count = cz ? CNT_W'(9) : '0;
              cyc;
              begin
                int exp_req;
                exp_req = int'(en == 1 && cz == 1 && f >= 1 && (g4 == 0 || f >= 4 || gr == 1));
                check(g4 ? "R3 write req" : "R2 write req", int'(bus_req), exp_req);
                if (exp_req == 1) check("R2 write chan", int'(chan_sel), 1);
              end
              quiet;
            end

    // R5 read qualification sweep
    cfg_wr_en = 0;
    for (int f = 0; f <= DEPTH; f++)
      for (int en = 0; en < 2; en++)
        for (int cz = 0; cz < 2; cz++) begin
          in_fill = FILL_W'(f); cfg_rd_en = en[0]; in_count = cz ? CNT_W'(3) : '0;
          cyc;
          check("R5 read req", int'(bus_req), int'(en == 1 && cz == 1 && f < DEPTH));
          if (en == 1 && cz == 1 && f < DEPTH) check("R5 read chan", int'(chan_sel), 0);
          quiet;
        end

    // R4 threshold waived while held; R11 hold without grant, drop after burst
    cfg_wr_gate4 = 1; out_count = 20; out_fill = 5; cfg_wr_en = 1;
    cyc;
    check("R4 write raised", int'(bus_req), 1);
    out_fill = 1;
    cyc; cyc;
    check("R4 held under threshold", int'(bus_req), 1);
    check("R11 chan held", int'(chan_sel), 1);
    bus_grant = 1;
    cyc; cyc;
    check("R11 owned", int'(bus_req), 1);
    burst_done = 1; bus_grant = 0;
    cyc;
    burst_done = 0;
    check("R11 drop after burst", int'(bus_req), 0);
    cyc;
    check("R3 no rerequest under threshold", int'(bus_req), 0);
    quiet;
    cfg_wr_gate4 = 0;

    // R10 suspend on enable clear
    out_fill = 3; out_count = 6; cfg_wr_en = 1;
    cyc;
    check("R10 write active", int'(bus_req), 1);
    cfg_wr_en = 0;
    #1;
    check("R10 suspend flag", int'(wr_suspend), 1);
    cyc;
    check("R10 request dropped", int'(bus_req), 0);
    out_count = 0;
    #1;
    check("R10 no suspend at zero count", int'(wr_suspend), 0);
    quiet;

    // common setup: both channels ready
    out_count = 30; out_fill = 6; in_count = 30; in_fill = 2;

    // R6 fixed read priority over several bursts
    cfg_rd_first = 1; cfg_wr_first = 0; bus_grant = 1;
    cfg_wr_en = 1; cfg_rd_en = 1;
    cyc;
    check("R6 read wins", int'(chan_sel), 0);
    for (int k = 0; k < 3; k++) begin
      next_burst;
      check("R6 read keeps winning", int'(chan_sel), 0);
    end
    quiet;

    // R7 alternation from reset
    do_reset;
    out_count = 30; out_fill = 6; in_count = 30; in_fill = 2;
    cfg_rd_first = 1; cfg_wr_first = 1; bus_grant = 1;
    cfg_wr_en = 1; cfg_rd_en = 1;
    cyc;
    check("R7 first pick read", int'(chan_sel), 0);
    for (int k = 1; k < 6; k++) begin
      next_burst;
      check("R7 alternate", int'(chan_sel), k % 2);
    end
    quiet;

    // R7 pointer unchanged when other channel idle
    do_reset;
    in_count = 30; in_fill = 2; out_count = 30; out_fill = 6;
    cfg_rd_first = 1; cfg_wr_first = 1; bus_grant = 1; cfg_rd_en = 1;
    cyc;
    next_burst;
    next_burst;
    check("R7 read only", int'(chan_sel), 0);
    quiet;
    cfg_rd_en = 1; cfg_wr_en = 1; bus_grant = 1;
    cyc;
    check("R7 pointer not moved", int'(chan_sel), 0);
    quiet;

    // R8 first-come, tie to read
    cfg_rd_first = 0; cfg_wr_first = 0;
    cfg_rd_en = 1; cfg_wr_en = 1; bus_grant = 1;
    cyc;
    check("R8 tie read", int'(chan_sel), 0);
    quiet;
    cfg_wr_en = 1; bus_grant = 1;
    cyc;
    check("R8 write alone", int'(chan_sel), 1);
    cyc;
    cfg_rd_en = 1;
    cyc;
    burst_done = 1;
    cyc;
    burst_done = 0;
    cyc;
    check("R8 earlier write served", int'(chan_sel), 1);
    check("R8 request up", int'(bus_req), 1);
    quiet;

    // R9 illegal mode
    cfg_rd_first = 0; cfg_wr_first = 1; cfg_rd_en = 1; cfg_wr_en = 1;
    cyc; cyc;
    check("R9 error flag", int'(cfg_error), 1);
    check("R9 no request", int'(bus_req), 0);
    cfg_rd_first = 1;
    cyc;
    check("R9 legal again", int'(bus_req), 1);
    cfg_rd_first = 0;
    cyc;
    check("R9 active dropped", int'(bus_req), 0);
    quiet;

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule